// File: doc/BRIEF.md
# Sticky Priority Polling Arbiter

This block decides which of three requesters owns a shared resource. On every rising clock edge it looks at three request flags and holds the result in a four-state machine. Exactly one of four states is live at a time: a free state in which nobody holds the resource, and one ownership state per requester. The three grant outputs are decoded from the stored state only, so they move solely on a clock edge.

When the resource is free, requester 0 has the highest priority and requester 2 the lowest. Once a requester owns the resource it keeps it for as long as it holds its request flag high. A higher-priority request arriving in the meantime does not take the resource away. When the owner drops its flag, the machine returns to the free state for at least one cycle before it grants again. At that free cycle the priority order is applied afresh, so a requester that never lowered its flag gets the resource back only if no higher-priority flag is up.

A parameter picks how the state is stored: a 2-bit binary code, or a 4-bit one-hot vector. The two choices give the same behaviour at the ports.

Top module: `spa_top`

## Requirements
- R1: A synchronous active-high reset puts the machine in the free state with all grant bits 0 at the next rising edge. While reset is held, no grant is given whatever the requests are.
- R2: At most one grant bit is 1 at any time. Grant bit i (bit position i of `gnt`) belongs to requester i (bit position i of `req`).
- R3: In the free state with `req[0]`=1, the next edge gives `gnt`=3'b001, whatever `req[2:1]` are.
- R4: In the free state with `req[0]`=0 and `req[1]`=1, the next edge gives `gnt`=3'b010, whatever `req[2]` is.
- R5: In the free state with only `req[2]`=1, the next edge gives `gnt`=3'b100. With `req`=3'b000 the machine stays free (`gnt`=3'b000).
- R6: While requester i owns the resource and `req[i]` stays 1, `gnt` stays one-hot on bit i across edges, whatever the other request bits do. There is no pre-emption.
- R7: When the owner's request bit is 0 at an edge, `gnt` becomes 3'b000 after that edge, even if other requests are pending.
- R8: After that free cycle, the priority order of R3 to R5 decides again. A requester that held its flag through the release regains the resource only when no higher-priority flag is up in the free cycle.
- R9: Grants are Moore outputs. A change of `req` between edges leaves `gnt` unchanged until the next rising edge.
- R10: Binary state storage (`ONEHOT_STATE`=0) and one-hot state storage (`ONEHOT_STATE`=1) give identical `gnt` sequences for the same inputs. In the one-hot form exactly one state bit is set out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 3 | Request flags; bit i is requester i, bit 0 is the highest priority |
| gnt | output | 3 | One-hot grant; bit i grants requester i; all zero when free |

## Verification
The bench builds two instances side by side, one with binary state storage and one with one-hot storage. It drives both with the same request stream and compares them on every sample, so both encodings are checked through each path of the machine. The directed sequences reach every state, release an owner while other requests are pending, show that a held low-priority grant is not lost when requester 0 arrives, and show that a continuously held request is granted again only when no higher-priority flag is up in the free cycle. Request changes made between edges show that the grant waits for the next edge.

// File: rtl/spa_pkg.sv
package spa_pkg;

    localparam int REQ_N   = 3;
    localparam int STATE_N = REQ_N + 1;
    localparam int STATE_W = $clog2(STATE_N);

    typedef logic [REQ_N-1:0]   req_vec_t;
    typedef logic [STATE_N-1:0] state_oh_t;

    typedef enum logic [STATE_W-1:0] {
        ST_FREE = 2'd0,
        ST_OWN0 = 2'd1,
        ST_OWN1 = 2'd2,
        ST_OWN2 = 2'd3
    } arb_state_e;

    // Grant vector implied by a state (Moore decode).
    function automatic req_vec_t grant_of(arb_state_e s);
        req_vec_t g;
        g = '0;
        case (s)
            ST_OWN0: g[0] = 1'b1;
            ST_OWN1: g[1] = 1'b1;
            ST_OWN2: g[2] = 1'b1;
            default: g = '0;
        endcase
        return g;
    endfunction

    // Fixed-priority choice made from the free state.
    function automatic arb_state_e pick_from_free(req_vec_t r);
        arb_state_e s;
        if (r[0])      s = ST_OWN0;
        else if (r[1]) s = ST_OWN1;
        else if (r[2]) s = ST_OWN2;
        else           s = ST_FREE;
        return s;
    endfunction

    function automatic state_oh_t to_onehot(arb_state_e s);
        state_oh_t v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

    function automatic arb_state_e from_onehot(state_oh_t v);
        arb_state_e s;
        s = ST_FREE;
        for (int k = 0; k < STATE_N; k++) begin
            if (v[k]) s = arb_state_e'(k[STATE_W-1:0]);
        end
        return s;
    endfunction

endpackage

// File: rtl/spa_next_state.sv
module spa_next_state
    import spa_pkg::*;
(
    input  arb_state_e cur,
    input  req_vec_t   req,
    output arb_state_e nxt
);

    req_vec_t owner_mask;

    always_comb begin
        owner_mask = grant_of(cur);
        if (cur == ST_FREE) begin
            nxt = pick_from_free(req);
        end else if ((owner_mask & req) != '0) begin
            nxt = cur;          // owner keeps the resource
        end else begin
            nxt = ST_FREE;      // release forces a free cycle
        end
    end

endmodule

// File: rtl/spa_state_store.sv
module spa_state_store
    import spa_pkg::*;
#(
    parameter bit ONEHOT_STATE = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  arb_state_e nxt,
    output arb_state_e cur
);

    generate
        if (ONEHOT_STATE) begin : g_onehot
            state_oh_t oh_q;

            always_ff @(posedge clk) begin
                if (rst) oh_q <= to_onehot(ST_FREE);
                else     oh_q <= to_onehot(nxt);
            end

            assign cur = from_onehot(oh_q);

            assert_state_onehot_R10: assert property (
                @(posedge clk) disable iff (rst)
                $past(rst) |-> ($countones(oh_q) == 1))
                else $error("one-hot state vector lost its single bit");
        end else begin : g_binary
            arb_state_e bin_q;

            always_ff @(posedge clk) begin
                if (rst) bin_q <= ST_FREE;
                else     bin_q <= nxt;
            end

            assign cur = bin_q;
        end
    endgenerate

endmodule

// File: rtl/spa_grant_decode.sv
module spa_grant_decode
    import spa_pkg::*;
(
    input  arb_state_e cur,
    output req_vec_t   gnt
);

    always_comb begin
        gnt = grant_of(cur);
    end

endmodule

// File: rtl/spa_top.sv
module spa_top
    import spa_pkg::*;
#(
    parameter bit ONEHOT_STATE = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] req,
    output logic [2:0] gnt
);

    arb_state_e cur_st;
    arb_state_e nxt_st;

    spa_next_state u_next (
        .cur (cur_st),
        .req (req),
        .nxt (nxt_st)
    );

    spa_state_store #(
        .ONEHOT_STATE (ONEHOT_STATE)
    ) u_store (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_st),
        .cur (cur_st)
    );

    spa_grant_decode u_dec (
        .cur (cur_st),
        .gnt (gnt)
    );

    // R1: reset leaves no grant
    assert_reset_free_R1: assert property (
        @(posedge clk) rst |=> (gnt == 3'b000))
        else $error("grant present after reset");

    // R2: never two grants
    assert_grant_onehot0_R2: assert property (
        @(posedge clk) disable iff (rst) $onehot0(gnt))
        else $error("more than one grant bit set");

    // R3: requester 0 wins from free
    assert_free_pick0_R3: assert property (
        @(posedge clk) disable iff (rst)
        (gnt == 3'b000 && req[0]) |=> (gnt == 3'b001))
        else $error("requester 0 not granted from free");

    // R4: requester 1 wins when 0 absent
    assert_free_pick1_R4: assert property (
        @(posedge clk) disable iff (rst)
        (gnt == 3'b000 && !req[0] && req[1]) |=> (gnt == 3'b010))
        else $error("requester 1 not granted from free");

    // R5: requester 2 alone, or nobody
    assert_free_pick2_R5: assert property (
        @(posedge clk) disable iff (rst)
        (gnt == 3'b000 && req == 3'b100) |=> (gnt == 3'b100))
        else $error("requester 2 not granted from free");

    assert_free_stay_R5: assert property (
        @(posedge clk) disable iff (rst)
        (gnt == 3'b000 && req == 3'b000) |=> (gnt == 3'b000))
        else $error("grant given with no request");

    // R6: owner keeps the grant while its request stays high
    assert_no_preempt_R6: assert property (
        @(posedge clk) disable iff (rst)
        ((gnt & req) != 3'b000) |=> (gnt == $past(gnt)))
        else $error("held grant was taken away");

    // R7: release always passes through free
    assert_release_free_R7: assert property (
        @(posedge clk) disable iff (rst)
        (gnt != 3'b000 && (gnt & req) == 3'b000) |=> (gnt == 3'b000))
        else $error("release did not pass through free");

endmodule

// File: tb/spa_top_tb.sv
`timescale 1ns/1ps
module spa_top_tb;

    logic       clk;
    logic       rst;
    logic [2:0] req;
    logic [2:0] gnt_bin;
    logic [2:0] gnt_oh;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    spa_top #(.ONEHOT_STATE(1'b0)) u_dut (
        .clk (clk), .rst (rst), .req (req), .gnt (gnt_bin)
    );

    spa_top #(.ONEHOT_STATE(1'b1)) u_dut_oh (
        .clk (clk), .rst (rst), .req (req), .gnt (gnt_oh)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    // Drive request at the falling edge.
    task automatic drive(input logic [2:0] v);
        @(negedge clk);
        req = v;
    endtask

    // Sample shortly after the next rising edge and compare both encodings.
    task automatic expect_gnt(input string tag, input logic [2:0] exp);
        @(posedge clk);
        #2;
        chk(tag, gnt_bin, exp);
        chk("R10 encodings agree", gnt_oh, gnt_bin);
        checks++;
        if ($countones(gnt_bin) > 1) begin
            failures++;
            $display("FAIL R2 got=%b expected=at most one bit", gnt_bin);
        end
    endtask

    task automatic step(input logic [2:0] v, input string tag, input logic [2:0] exp);
        drive(v);
        expect_gnt(tag, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        req = 3'b111;
        expect_gnt("R1 reset with requests", 3'b000);
        expect_gnt("R1 reset held", 3'b000);
        drive(3'b000);
        rst = 1'b0;
        expect_gnt("R5 free stays free", 3'b000);
    endtask

    task automatic t_priority();
        step(3'b111, "R3 req0 wins", 3'b001);
        step(3'b000, "R7 release to free", 3'b000);
        step(3'b110, "R4 req1 wins over req2", 3'b010);
        step(3'b000, "R7 release to free", 3'b000);
        step(3'b100, "R5 req2 alone", 3'b100);
        step(3'b000, "R7 release to free", 3'b000);
        step(3'b000, "R5 no request stays free", 3'b000);
    endtask

    task automatic t_hold_and_regrant();
        step(3'b100, "R5 req2 granted", 3'b100);
        step(3'b111, "R6 req2 kept against req0", 3'b100);
        step(3'b101, "R6 req2 kept", 3'b100);
        step(3'b011, "R7 free despite pending", 3'b000);
        step(3'b011, "R8 higher req0 wins after free", 3'b001);
        step(3'b010, "R7 release with req1 pending", 3'b000);
        step(3'b010, "R8 held req1 regranted", 3'b010);
        step(3'b011, "R6 req1 kept against req0", 3'b010);
        step(3'b001, "R7 release with req0 pending", 3'b000);
        step(3'b000, "R5 free", 3'b000);
    endtask

    task automatic t_moore();
        @(negedge clk);
        req = 3'b001;
        #1;
        chk("R9 no grant before edge", gnt_bin, 3'b000);
        expect_gnt("R9 grant after edge", 3'b001);
        @(negedge clk);
        req = 3'b000;
        #1;
        chk("R9 grant held until edge", gnt_bin, 3'b001);
        expect_gnt("R7 free after drop", 3'b000);
    endtask

    task automatic t_reset_while_owned();
        step(3'b010, "R4 req1 granted", 3'b010);
        drive(3'b010);
        rst = 1'b1;
        expect_gnt("R1 reset removes grant", 3'b000);
        drive(3'b010);
        rst = 1'b0;
        expect_gnt("R4 granted again after reset", 3'b010);
        step(3'b000, "R7 release", 3'b000);
    endtask

    initial begin
        t_reset();
        t_priority();
        t_hold_and_regrant();
        t_moore();
        t_reset_while_owned();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog got=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule